// File: doc/BRIEF.md
# Prescaled Match Timer

This block is a free-running 32-bit timer for a peripheral subsystem. A prescale counter runs on every clock while the timer is enabled. Each time it reaches the programmed prescale value it wraps, and that tick advances the main timer count. Four compare channels watch the timer count. Each channel has its own three-bit action field in a match control word, so a compare hit can set an interrupt flag, send the count back to zero, or halt the timer and drop the run enable. A hit can also do any combination of these.

Software uses a plain write port and a combinational read port. Through them it sets the prescale value, the four compare values and the action word, and it starts or holds the timer. Interrupt flags stay set until software writes one to them. The interrupt line is high while any flag is set. There is no streaming data path: all pins are control and status, so the port has no valid/ready handshake. A write is taken on the clock edge where `wr_en` is high.

Top module: `match_timer`

## Requirements
- R1: After reset, every register reads zero: control, prescale value, match control, flags, the compare values, timer count and prescale count. `irq` is low.
- R2: While the enable bit (control bit 0) is 1 and the hold bit (control bit 1) is 0, the prescale count rises by one per clock. When it has reached the prescale value P, the next clock returns it to zero and advances the timer count, so the timer count moves once every P+1 clocks.
- R3: While the enable bit is 0, both counters keep their values.
- R4: While the hold bit is 1, both counters are forced to zero and stay there.
- R5: In the match control word, channel k owns bits 3k, 3k+1 and 3k+2. These are, in that order, interrupt enable, count reset and stop.
- R6: A channel acts only on a prescale tick that brings the timer count to its compare value. A count that already equals the compare value without such a tick, for example after a compare value is written, triggers nothing.
- R7: With count reset enabled, the hitting tick loads zero into the timer count instead of the compare value.
- R8: With stop enabled, a hit clears the enable bit, which overrides a control write in the same cycle, and both counters freeze. The timer count then holds the compare value, or zero if count reset is also enabled.
- R9: When several channels hit on the same tick, every enabled action of every hitting channel takes effect.
- R10: A hit with interrupt enable sets that channel's flag (flag bit k). A flag stays set until software writes 1 to its bit at the flag address, and a hit in the same cycle wins over the clear. Zero bits in that write leave flags unchanged. `irq` is high exactly while any flag is set.
- R11: Address map (4-bit): 0 control, 1 prescale value, 2 match control (12 bits), 3 flags, 4+k compare value of channel k, 8 timer count (read only), 9 prescale count (read only). Any other address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that drives both counters |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 32 | Combinational read data |
| irq | output | 1 | Level interrupt, OR of all flags |

## Verification
The bench checks the hit at the exact tick. A design that compares the old count would wrap one count late, and reset mode would reach the compare value before falling to zero. It checks prescale values above zero, where a design counting every clock or every P clocks ends on a wrong count. It checks stop with and without reset, where a wrong design leaves the enable bit set or parks on the wrong count. It checks two channels hitting on one tick, and the top channel's stop bit at bit 11, which catches a bit-field misplacement. It also checks that writing a compare value equal to a frozen count raises no flag, and that write-one-clear touches only the selected flag bit.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 4;
  localparam int ACT_W  = 3;
  // Position of each action inside a channel's field
  localparam int ACT_IRQ  = 0;
  localparam int ACT_CLR  = 1;
  localparam int ACT_STOP = 2;

  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
  localparam logic [ADDR_W-1:0] A_PRESC  = 4'd1;
  localparam logic [ADDR_W-1:0] A_MCTL   = 4'd2;
  localparam logic [ADDR_W-1:0] A_FLAGS  = 4'd3;
  localparam logic [ADDR_W-1:0] A_MATCH0 = 4'd4;
  localparam logic [ADDR_W-1:0] A_TC     = 4'd8;
  localparam logic [ADDR_W-1:0] A_PC     = 4'd9;
endpackage

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         hold,
  input  logic [W-1:0] presc,
  input  logic         wrap,
  output logic         tick,
  output logic [W-1:0] tc_inc,
  output logic [W-1:0] tc,
  output logic [W-1:0] pc
);
  logic run;

  assign run    = en & ~hold;
  assign tick   = run && (pc >= presc);
  assign tc_inc = tc + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0;
      tc <= '0;
    end else if (hold) begin
      pc <= '0;
      tc <= '0;
    end else if (run) begin
      if (tick) begin
        pc <= '0;
        tc <= wrap ? '0 : tc_inc;
      end else begin
        pc <= pc + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tmr_match.sv
module tmr_match #(
  parameter int W   = 32,
  parameter int NCH = 4
) (
  input  logic                    tick,
  input  logic [W-1:0]            tc_inc,
  input  logic [NCH-1:0][W-1:0]   mval,
  input  logic [tmr_pkg::ACT_W*NCH-1:0] mctl,
  output logic [NCH-1:0]          hit,
  output logic [NCH-1:0]          rst_sel,
  output logic [NCH-1:0]          stop_sel,
  output logic [NCH-1:0]          flag_set,
  output logic                    wrap,
  output logic                    stop_req
);
  import tmr_pkg::*;

  logic [NCH-1:0] irq_sel;

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    assign hit[k]      = tick && (tc_inc == mval[k]);
    assign irq_sel[k]  = mctl[ACT_W*k + ACT_IRQ];
    assign rst_sel[k]  = mctl[ACT_W*k + ACT_CLR];
    assign stop_sel[k] = mctl[ACT_W*k + ACT_STOP];
  end

  assign flag_set = hit & irq_sel;
  assign wrap     = |(hit & rst_sel);
  assign stop_req = |(hit & stop_sel);
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs #(
  parameter int W   = 32,
  parameter int NCH = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [tmr_pkg::ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]            wr_data,
  input  logic [tmr_pkg::ADDR_W-1:0] rd_addr,
  output logic [W-1:0]            rd_data,
  input  logic [W-1:0]            tc,
  input  logic [W-1:0]            pc,
  input  logic                    stop_req,
  input  logic [NCH-1:0]          flag_set,
  output logic                    en,
  output logic                    hold,
  output logic [W-1:0]            presc,
  output logic [tmr_pkg::ACT_W*NCH-1:0] mctl,
  output logic [NCH-1:0][W-1:0]   mval,
  output logic [NCH-1:0]          flags
);
  import tmr_pkg::*;

  localparam int MW = ACT_W * NCH;

  logic [NCH-1:0] clr;

  assign clr = (wr_en && wr_addr == A_FLAGS) ? wr_data[NCH-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en    <= 1'b0;
      hold  <= 1'b0;
      presc <= '0;
      mctl  <= '0;
      mval  <= '0;
      flags <= '0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          A_CTRL:  begin en <= wr_data[0]; hold <= wr_data[1]; end
          A_PRESC: presc <= wr_data;
          A_MCTL:  mctl  <= wr_data[MW-1:0];
          default: ;
        endcase
        for (int k = 0; k < NCH; k++)
          if (wr_addr == ADDR_W'(A_MATCH0 + k)) mval[k] <= wr_data;
      end
      // hardware stop overrides a same-cycle control write
      if (stop_req) en <= 1'b0;
      flags <= (flags & ~clr) | flag_set;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL:  rd_data[1:0]    = {hold, en};
      A_PRESC: rd_data         = presc;
      A_MCTL:  rd_data[MW-1:0] = mctl;
      A_FLAGS: rd_data[NCH-1:0] = flags;
      A_TC:    rd_data         = tc;
      A_PC:    rd_data         = pc;
      default: ;
    endcase
    for (int k = 0; k < NCH; k++)
      if (rd_addr == ADDR_W'(A_MATCH0 + k)) rd_data = mval[k];
  end
endmodule

// File: rtl/match_timer.sv
module match_timer #(
  parameter int W   = 32,
  parameter int NCH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [3:0]   wr_addr,
  input  logic [31:0]  wr_data,
  input  logic [3:0]   rd_addr,
  output logic [31:0]  rd_data,
  output logic         irq
);
  import tmr_pkg::*;

  localparam int MW = ACT_W * NCH;

  logic                  en, hold, tick, wrap, stop_req;
  logic [W-1:0]          presc, tc, pc, tc_inc;
  logic [MW-1:0]         mctl;
  logic [NCH-1:0][W-1:0] mval;
  logic [NCH-1:0]        flags, flag_set, hit, rst_sel, stop_sel;

  tmr_regs #(.W(W), .NCH(NCH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .tc(tc), .pc(pc), .stop_req(stop_req), .flag_set(flag_set),
    .en(en), .hold(hold), .presc(presc), .mctl(mctl), .mval(mval),
    .flags(flags)
  );

  tmr_count #(.W(W)) u_count (
    .clk(clk), .rst_n(rst_n), .en(en), .hold(hold), .presc(presc),
    .wrap(wrap), .tick(tick), .tc_inc(tc_inc), .tc(tc), .pc(pc)
  );

  tmr_match #(.W(W), .NCH(NCH)) u_match (
    .tick(tick), .tc_inc(tc_inc), .mval(mval), .mctl(mctl), .hit(hit),
    .rst_sel(rst_sel), .stop_sel(stop_sel), .flag_set(flag_set),
    .wrap(wrap), .stop_req(stop_req)
  );

  assign irq = |flags;
endmodule

// File: rtl/match_timer_chk.sv
module match_timer_chk #(
  parameter int W   = 32,
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           en,
  input logic           hold,
  input logic [W-1:0]   tc,
  input logic [W-1:0]   pc,
  input logic [NCH-1:0] hit,
  input logic [NCH-1:0] rst_sel,
  input logic [NCH-1:0] stop_sel,
  input logic [NCH-1:0] flags,
  input logic           wr_en,
  input logic [3:0]     wr_addr,
  input logic [31:0]    wr_data
);
  import tmr_pkg::*;

  logic [NCH-1:0] clr_mask;
  assign clr_mask = (wr_en && wr_addr == A_FLAGS) ? wr_data[NCH-1:0] : '0;

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !hold) |=> (tc == $past(tc) || tc == $past(tc) + 1'b1 || tc == '0));

  p_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !hold) |=> (tc == $past(tc) && pc == $past(pc)));

  p_hold_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (tc == '0 && pc == '0));

  p_wrap_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(hit & rst_sel)) |=> (tc == '0));

  p_stop_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(hit & stop_sel)) |=> !en);

  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & $past(flags & ~clr_mask)) == $past(flags & ~clr_mask)));

  p_flag_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & ~$past(flags) & ~$past(hit)) == '0));
endmodule

bind match_timer match_timer_chk #(.W(W), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .hold(hold), .tc(tc), .pc(pc),
  .hit(hit), .rst_sel(rst_sel), .stop_sel(stop_sel), .flags(flags),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/match_timer_tb_top.sv
`timescale 1ns/1ps
module match_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  match_timer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  // presc, match0, ch0 action bits, clocks, exp count, exp flag0, exp enable
  localparam int unsigned VEC [8][7] = '{
    '{0, 100, 0, 10, 10, 0, 1},
    '{3, 100, 0, 20,  5, 0, 1},
    '{0,   5, 1, 10, 10, 1, 1},
    '{0,   5, 2, 12,  2, 0, 1},
    '{0,   5, 4, 10,  5, 0, 0},
    '{1,   3, 3, 11,  2, 1, 1},
    '{0,   4, 6,  9,  0, 0, 0},
    '{2,   2, 5, 20,  2, 1, 0}
  };

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_addr = a;
    #0.5;
    d = rd_data;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic setup(input logic [31:0] p, input logic [31:0] mcr);
    wr(4'd0, 32'd2);
    wr(4'd3, 32'hF);
    wr(4'd2, mcr);
    wr(4'd1, p);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'd0, v); check("R1 control", v, 0);
    rd(4'd2, v); check("R1 match control", v, 0);
    rd(4'd8, v); check("R1 timer count", v, 0);
    rd(4'd9, v); check("R1 prescale count", v, 0);
    rd(4'd3, v); check("R1 flags", v, 0);
    check("R1 irq", {31'd0, irq}, 0);

    // table walk: R2 R5 R7 R8 on channel 0
    for (int i = 0; i < 8; i++) begin
      setup(VEC[i][0], VEC[i][2]);
      wr(4'd4, VEC[i][1]);
      wr(4'd0, 32'd1);
      repeat (VEC[i][3]) @(negedge clk);
      rd(4'd8, v); check($sformatf("R2 R7 R8 count vec %0d", i), v, VEC[i][4]);
      rd(4'd3, v); check($sformatf("R5 R10 flag vec %0d", i), v, VEC[i][5]);
      rd(4'd0, v); check($sformatf("R8 enable vec %0d", i), v, VEC[i][6]);
    end

    // R9 two channels on one tick: ch0 interrupt, ch1 reset
    setup(0, (32'd1 << 0) | (32'd1 << 4));
    wr(4'd4, 3); wr(4'd5, 3);
    wr(4'd0, 32'd1);
    repeat (4) @(negedge clk);
    rd(4'd8, v); check("R9 count after joint hit", v, 1);
    rd(4'd3, v); check("R9 flags after joint hit", v, 1);

    // R5 upper fields: ch2 interrupt (bit 6), ch3 stop (bit 11)
    setup(0, (32'd1 << 6) | (32'd1 << 11));
    wr(4'd4, 1000); wr(4'd5, 1000); wr(4'd6, 2); wr(4'd7, 7);
    wr(4'd0, 32'd1);
    repeat (10) @(negedge clk);
    rd(4'd8, v); check("R5 R8 ch3 stop count", v, 7);
    rd(4'd0, v); check("R5 R8 ch3 stop enable", v, 0);
    rd(4'd3, v); check("R5 ch2 flag", v, 32'h4);

    // R6 compare value written equal to a frozen count: no action
    wr(4'd2, (32'd1 << 3) | (32'd1 << 6) | (32'd1 << 11));
    wr(4'd5, 7);
    repeat (3) @(negedge clk);
    rd(4'd3, v); check("R6 no flag without tick", v, 32'h4);

    // R10 write-one-clear per bit, irq level
    check("R10 irq high", {31'd0, irq}, 1);
    wr(4'd3, 32'h1);
    rd(4'd3, v); check("R10 unrelated clear bit", v, 32'h4);
    wr(4'd3, 32'h4);
    rd(4'd3, v); check("R10 flag cleared", v, 0);
    check("R10 irq low", {31'd0, irq}, 0);

    // R3 freeze on enable clear
    setup(0, 0);
    wr(4'd0, 32'd1);
    repeat (6) @(negedge clk);
    wr(4'd0, 32'd0);
    repeat (10) @(negedge clk);
    rd(4'd8, v); check("R3 frozen count", v, 8);

    // R2 prescale count phase, R11 readback
    setup(3, 0);
    wr(4'd0, 32'd1);
    repeat (6) @(negedge clk);
    rd(4'd9, v); check("R2 prescale count", v, 2);
    rd(4'd8, v); check("R2 count with prescale", v, 1);
    rd(4'd1, v); check("R11 prescale readback", v, 3);
    rd(4'd6, v); check("R11 compare readback", v, 2);
    rd(4'd12, v); check("R11 unused address", v, 0);

    // R4 hold forces zero even with enable set
    wr(4'd0, 32'd3);
    repeat (10) @(negedge clk);
    rd(4'd8, v); check("R4 held count", v, 0);
    rd(4'd9, v); check("R4 held prescale", v, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule